// File: doc/BRIEF.md
# Placeholder-Tag Operand Gate

This block sits between the operand read path (register file or memory) and the execute stage of a processor whose words carry a type tag. Each word is 36 bits: a 4-bit tag in bits 35:32 above a 32-bit data field. Two tag codes mark a slot whose value is still being computed. The block looks at the tag of every operand and either forwards the word unchanged or raises a trap request with a cause code.

A single-slot placeholder (tag 4'hE) traps on every access. A future placeholder (tag 4'hF) may be copied freely and traps only when it is consumed. All other tags are ordinary data and always pass.

Operands enter on a valid/ready stream. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. A word that passes leaves on a registered valid/ready stream. `in_ready` is low while the output register holds a word the consumer has not taken, and while an unacknowledged trap is pending. A faulting access produces a one-cycle `trap_req` pulse. The faulting tag, the operation kind and the cause stay on the trap outputs until `trap_ack`.

A separate store-notification port compares the old and new tag of a slot being written. When a real value replaces a placeholder, the block issues a one-cycle wakeup pulse that carries the slot address.

Top module: `tag_sync_gate`

## Requirements
- R1: A passing operand appears on `out_word` bit-for-bit unchanged, with `out_valid` high, in the cycle after it is accepted. Tag is bits 35:32, data is bits 31:0.
- R2: An operand with tag 4'hE traps with cause 2'd1 for both operation kinds (`in_op` 0 = copy, 1 = consume) and is not forwarded.
- R3: An operand with tag 4'hF and `in_op` = 0 (copy) passes without a trap.
- R4: An operand with tag 4'hF and `in_op` = 1 (consume) traps with cause 2'd2 and is not forwarded.
- R5: Operands with any tag other than 4'hE and 4'hF pass for both operation kinds.
- R6: `trap_req` is high for exactly the one cycle after a faulting operand is accepted. `trap_pending`, `trap_tag`, `trap_op` and `trap_cause` hold until `trap_ack` is high on a clock edge. `in_ready` stays low while `trap_pending` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_word` is held and `in_ready` is low. When `out_ready` is high, a new operand may be accepted on the same edge that the held word is taken.
- R8: When `wr_valid` is high, `wr_old_tag` is 4'hE or 4'hF, and `wr_new_tag` is neither, `wake_pulse` is high for one cycle on the next cycle and `wake_addr` equals `wr_addr`.
- R9: A store that leaves a placeholder tag in place, or that overwrites ordinary data, produces no wakeup.
- R10: `trap_req`, a new `out_valid` and `wake_pulse` assert only as a result of an accepted operand or a valid store. Inputs presented with their valid low have no effect.
- R11: After reset, `out_valid`, `trap_req`, `trap_pending` and `wake_pulse` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be accepted |
| in_word | input | 36 | Tagged operand word |
| in_op | input | 1 | Operation kind: 0 copy, 1 consume |
| out_valid | output | 1 | Forwarded operand present (pass) |
| out_ready | input | 1 | Execute stage takes the operand |
| out_word | output | 36 | Forwarded operand |
| trap_req | output | 1 | One-cycle trap request |
| trap_pending | output | 1 | Trap awaiting acknowledge |
| trap_cause | output | 2 | 1 single-slot placeholder, 2 future consumed |
| trap_tag | output | 4 | Tag of faulting operand |
| trap_op | output | 1 | Operation kind of faulting access |
| trap_ack | input | 1 | Acknowledge of pending trap |
| wr_valid | input | 1 | Store notification present |
| wr_addr | input | 12 | Slot address of the store |
| wr_old_tag | input | 4 | Tag previously held by the slot |
| wr_new_tag | input | 4 | Tag being stored |
| wake_pulse | output | 1 | One-cycle wakeup event |
| wake_addr | output | 12 | Slot address for the wakeup |

## Verification
A wrong decode of a tag shows up in the first cycle after the operand is accepted. It appears either as a forwarded placeholder or as a trap with the wrong cause, so each tag and operation pair is applied and checked one cycle after acceptance. A trap register that loses its pending state or its captured fields shows up at once as `in_ready` returning high, or as trap fields that change before the acknowledge. A stuck output register shows up as a changing `out_word` under back-pressure. The wakeup detector is checked in the cycle after each store, and again one cycle later to make sure the pulse has dropped.

// File: rtl/tag_sync_pkg.sv
package tag_sync_pkg;
  localparam logic [3:0] SLOT_TAG_DEF = 4'hE;
  localparam logic [3:0] FUT_TAG_DEF  = 4'hF;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_SLOT   = 2'd1,
    CAUSE_FUTURE = 2'd2
  } trap_cause_e;

  typedef enum logic {
    OP_COPY    = 1'b0,
    OP_CONSUME = 1'b1
  } op_kind_e;
endpackage

// File: rtl/tag_classifier.sv
module tag_classifier
  import tag_sync_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter logic [TAG_W-1:0] SLOT_TAG = SLOT_TAG_DEF,
  parameter logic [TAG_W-1:0] FUT_TAG  = FUT_TAG_DEF
) (
  input  logic [TAG_W-1:0] tag,
  input  logic             op,
  output logic             must_trap,
  output logic [1:0]       cause
);
  trap_cause_e c;

  always_comb begin
    c = CAUSE_NONE;
    if (tag == SLOT_TAG) begin
      c = CAUSE_SLOT;
    end else if (tag == FUT_TAG && op == OP_CONSUME) begin
      c = CAUSE_FUTURE;
    end
  end

  assign cause     = c;
  assign must_trap = (c != CAUSE_NONE);
endmodule

// File: rtl/pass_stage.sv
module pass_stage #(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_word  <= load_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_latch.sv
module trap_latch #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [TAG_W-1:0] cap_tag,
  input  logic             cap_op,
  input  logic [1:0]       cap_cause,
  input  logic             ack,
  output logic             trap_req,
  output logic             trap_pending,
  output logic [TAG_W-1:0] trap_tag,
  output logic             trap_op,
  output logic [1:0]       trap_cause
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req     <= 1'b0;
      trap_pending <= 1'b0;
      trap_tag     <= '0;
      trap_op      <= 1'b0;
      trap_cause   <= 2'd0;
    end else begin
      trap_req <= capture;
      if (capture) begin
        trap_pending <= 1'b1;
        trap_tag     <= cap_tag;
        trap_op      <= cap_op;
        trap_cause   <= cap_cause;
      end else if (ack) begin
        trap_pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wake_detect.sv
module wake_detect
  import tag_sync_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int TAG_W  = 4,
  parameter logic [TAG_W-1:0] SLOT_TAG = SLOT_TAG_DEF,
  parameter logic [TAG_W-1:0] FUT_TAG  = FUT_TAG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TAG_W-1:0]  old_tag,
  input  logic [TAG_W-1:0]  new_tag,
  output logic              wake_pulse,
  output logic [ADDR_W-1:0] wake_addr
);
  logic old_ph, new_ph, fire;

  assign old_ph = (old_tag == SLOT_TAG) || (old_tag == FUT_TAG);
  assign new_ph = (new_tag == SLOT_TAG) || (new_tag == FUT_TAG);
  assign fire   = wr_valid && old_ph && !new_ph;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wake_pulse <= 1'b0;
      wake_addr  <= '0;
    end else begin
      wake_pulse <= fire;
      if (fire) wake_addr <= wr_addr;
    end
  end
endmodule

// File: rtl/tag_sync_gate.sv
module tag_sync_gate
  import tag_sync_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 12,
  parameter logic [TAG_W-1:0] SLOT_TAG = SLOT_TAG_DEF,
  parameter logic [TAG_W-1:0] FUT_TAG  = FUT_TAG_DEF,
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              trap_req,
  output logic              trap_pending,
  output logic [1:0]        trap_cause,
  output logic [TAG_W-1:0]  trap_tag,
  output logic              trap_op,
  input  logic              trap_ack,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [TAG_W-1:0]  wr_old_tag,
  input  logic [TAG_W-1:0]  wr_new_tag,
  output logic              wake_pulse,
  output logic [ADDR_W-1:0] wake_addr
);
  logic [TAG_W-1:0] in_tag;
  logic             must_trap;
  logic [1:0]       cls_cause;
  logic             accept;

  assign in_tag   = in_word[WORD_W-1 -: TAG_W];
  assign in_ready = (!out_valid || out_ready) && !trap_pending;
  assign accept   = in_valid && in_ready;

  tag_classifier #(
    .TAG_W(TAG_W), .SLOT_TAG(SLOT_TAG), .FUT_TAG(FUT_TAG)
  ) cls_i (
    .tag(in_tag), .op(in_op), .must_trap(must_trap), .cause(cls_cause)
  );

  pass_stage #(.WORD_W(WORD_W)) pass_i (
    .clk(clk), .rst_n(rst_n),
    .load(accept && !must_trap), .load_word(in_word),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word)
  );

  trap_latch #(.TAG_W(TAG_W)) trap_i (
    .clk(clk), .rst_n(rst_n),
    .capture(accept && must_trap), .cap_tag(in_tag), .cap_op(in_op),
    .cap_cause(cls_cause), .ack(trap_ack),
    .trap_req(trap_req), .trap_pending(trap_pending),
    .trap_tag(trap_tag), .trap_op(trap_op), .trap_cause(trap_cause)
  );

  wake_detect #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .SLOT_TAG(SLOT_TAG), .FUT_TAG(FUT_TAG)
  ) wake_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .old_tag(wr_old_tag), .new_tag(wr_new_tag),
    .wake_pulse(wake_pulse), .wake_addr(wake_addr)
  );
endmodule

// File: rtl/tag_sync_gate_chk.sv
module tag_sync_gate_chk #(
  parameter int WORD_W = 36,
  parameter int TAG_W  = 4,
  parameter int ADDR_W = 12,
  parameter logic [TAG_W-1:0] SLOT_TAG = 4'hE
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              trap_req,
  input logic              trap_pending,
  input logic [1:0]        trap_cause,
  input logic [TAG_W-1:0]  trap_tag,
  input logic              trap_ack,
  input logic              wr_valid,
  input logic              wake_pulse
);
  a_r2_slot_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_word[WORD_W-1 -: TAG_W] == SLOT_TAG)
      |=> (trap_req && trap_cause == 2'd1 && !out_valid));

  a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);

  a_r6_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pending && !trap_ack)
      |=> (trap_pending && $stable(trap_cause) && $stable(trap_tag)));

  a_r6_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pending |-> !in_ready);

  a_r7_backpressure_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  a_r10_trap_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_req) |-> $past(in_valid && in_ready));

  a_r10_wake_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(wr_valid));
endmodule

bind tag_sync_gate tag_sync_gate_chk #(
  .WORD_W(WORD_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .SLOT_TAG(SLOT_TAG)
) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .trap_req(trap_req), .trap_pending(trap_pending),
  .trap_cause(trap_cause), .trap_tag(trap_tag), .trap_ack(trap_ack),
  .wr_valid(wr_valid), .wake_pulse(wake_pulse)
);

// File: tb/tag_sync_gate_tb_top.sv
`timescale 1ns/1ps
module tag_sync_gate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_op;
  logic [35:0] in_word;
  logic        out_valid, out_ready;
  logic [35:0] out_word;
  logic        trap_req, trap_pending, trap_op, trap_ack;
  logic [1:0]  trap_cause;
  logic [3:0]  trap_tag;
  logic        wr_valid;
  logic [11:0] wr_addr, wake_addr;
  logic [3:0]  wr_old_tag, wr_new_tag;
  logic        wake_pulse;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  tag_sync_gate dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word), .trap_req(trap_req),
    .trap_pending(trap_pending), .trap_cause(trap_cause),
    .trap_tag(trap_tag), .trap_op(trap_op), .trap_ack(trap_ack),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_old_tag(wr_old_tag),
    .wr_new_tag(wr_new_tag), .wake_pulse(wake_pulse), .wake_addr(wake_addr)
  );

  // {tag[3:0], op, expected cause[1:0]}; cause 0 means the word passes
  localparam logic [6:0] VEC [0:11] = '{
    {4'h0, 1'b0, 2'd0}, {4'h0, 1'b1, 2'd0}, {4'h5, 1'b1, 2'd0},
    {4'hD, 1'b0, 2'd0}, {4'hD, 1'b1, 2'd0}, {4'hE, 1'b0, 2'd1},
    {4'hE, 1'b1, 2'd1}, {4'hF, 1'b0, 2'd0}, {4'hF, 1'b1, 2'd2},
    {4'h7, 1'b0, 2'd0}, {4'hC, 1'b1, 2'd0}, {4'h1, 1'b1, 2'd0}
  };

  task automatic check(input bit ok, input string req,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present one operand for one edge, sample at the following negedge
  task automatic send(input logic [3:0] tag, input logic op,
                      input logic [31:0] data);
    @(negedge clk);
    in_valid = 1'b1; in_word = {tag, data}; in_op = op;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic ack_trap();
    trap_ack = 1'b1;
    @(negedge clk);
    trap_ack = 1'b0;
  endtask

  task automatic store(input logic [11:0] a, input logic [3:0] o,
                       input logic [3:0] n);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_old_tag = o; wr_new_tag = n;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", total);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_op = 1'b0;
    out_ready = 1'b1; trap_ack = 1'b0;
    wr_valid = 1'b0; wr_addr = '0; wr_old_tag = '0; wr_new_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check({out_valid, trap_req, trap_pending, wake_pulse, in_ready} == 5'b00001,
          "R11", {31'd0, out_valid, trap_req, trap_pending, wake_pulse, in_ready},
          36'h1);

    // R10 inputs with valid low: placeholder operand and wakeup store
    in_word = {4'hE, 32'h1234}; in_op = 1'b1;
    wr_addr = 12'h055; wr_old_tag = 4'hE; wr_new_tag = 4'h2;
    repeat (3) @(negedge clk);
    check(!trap_req && !trap_pending && !out_valid && !wake_pulse, "R10",
          {32'd0, trap_req, trap_pending, out_valid, wake_pulse}, 36'h0);

    // table walk: R1 R2 R3 R4 R5
    for (int i = 0; i < 12; i++) begin
      logic [3:0]  t;
      logic        o;
      logic [1:0]  c;
      logic [31:0] d;
      string       rq;
      t = VEC[i][6:3]; o = VEC[i][2]; c = VEC[i][1:0];
      d = 32'hA500_0000 ^ (32'h0001_1111 * (i + 1));
      rq = (t == 4'hE) ? "R2" : (t == 4'hF) ? (o ? "R4" : "R3") : "R5";
      send(t, o, d);
      if (c == 2'd0) begin
        check(out_valid && !trap_req, rq, {34'd0, out_valid, trap_req}, 36'h2);
        check(out_word == {t, d}, "R1", out_word, {t, d});
      end else begin
        check(trap_req && !out_valid && trap_cause == c, rq,
              {32'd0, trap_req, out_valid, trap_cause}, {32'd0, 2'b10, c});
        check(trap_tag == t && trap_op == o && trap_pending, "R6",
              {31'd0, trap_tag, trap_op}, {31'd0, t, o});
        ack_trap();
        check(!trap_pending && in_ready, "R6",
              {34'd0, trap_pending, in_ready}, 36'h1);
      end
    end

    // R6 trap held, input blocked while pending
    send(4'hF, 1'b1, 32'hCAFE_0001);
    in_valid = 1'b1; in_word = {4'h3, 32'h0BAD_0BAD}; in_op = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!trap_req && trap_pending && !in_ready && !out_valid, "R6",
          {32'd0, trap_req, trap_pending, in_ready, out_valid}, 36'h4);
    check(trap_cause == 2'd2 && trap_tag == 4'hF && trap_op == 1'b1, "R6",
          {29'd0, trap_cause, trap_tag, trap_op}, {29'd0, 2'd2, 4'hF, 1'b1});
    in_valid = 1'b0;
    ack_trap();
    check(!trap_pending && !out_valid, "R6",
          {34'd0, trap_pending, out_valid}, 36'h0);

    // R7 back-pressure
    out_ready = 1'b0;
    send(4'h2, 1'b1, 32'h1111_2222);
    check(out_valid && !in_ready && out_word == {4'h2, 32'h1111_2222}, "R7",
          out_word, {4'h2, 32'h1111_2222});
    in_valid = 1'b1; in_word = {4'h4, 32'h3333_4444}; in_op = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_valid && out_word == {4'h2, 32'h1111_2222}, "R7",
          out_word, {4'h2, 32'h1111_2222});
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_word == {4'h4, 32'h3333_4444}, "R7",
          out_word, {4'h4, 32'h3333_4444});
    @(negedge clk);
    check(!out_valid, "R7", {35'd0, out_valid}, 36'h0);

    // R8 wakeups
    store(12'h3A1, 4'hE, 4'h3);
    check(wake_pulse && wake_addr == 12'h3A1, "R8",
          {23'd0, wake_pulse, wake_addr}, {23'd0, 1'b1, 12'h3A1});
    @(negedge clk);
    check(!wake_pulse, "R8", {35'd0, wake_pulse}, 36'h0);
    store(12'h07F, 4'hF, 4'h0);
    check(wake_pulse && wake_addr == 12'h07F, "R8",
          {23'd0, wake_pulse, wake_addr}, {23'd0, 1'b1, 12'h07F});

    // R9 no wakeup
    store(12'h100, 4'hE, 4'hF);
    check(!wake_pulse, "R9", {35'd0, wake_pulse}, 36'h0);
    store(12'h101, 4'h2, 4'h5);
    check(!wake_pulse, "R9", {35'd0, wake_pulse}, 36'h0);
    store(12'h102, 4'h1, 4'hE);
    check(!wake_pulse, "R9", {35'd0, wake_pulse}, 36'h0);

    finish_run();
  end
endmodule